// File: doc/BRIEF.md
# Two-Port Audio Interrupt Aggregator

This block takes the FIFO service requests of two audio ports and folds them into one interrupt line for the CPU. Each port has an output and an input direction, so there are four request sources. A rising edge on a request sets a sticky status bit. That bit reaches the interrupt line only when software has set the matching bit in both the interrupt mask register and the enable-mask register.

Software reaches four word registers through a plain single-cycle write port. Reads are combinational from the address. There is no stream data path, so the block has no valid/ready handshake and no back-pressure.

Software can clear status in three ways:
- A write to the status register clears every bit written as 0. A write of zero therefore clears everything, and a read-modify-write clears only the bits chosen.
- An active-low interrupt-reset bit in the soft-reset register clears status.
- An active-low global-reset bit in the same register also clears status.

The soft-reset register also drives the two per-port reset outputs.

Top module: `audio_irq_aggr`

## Requirements
- R1: After reset, status, mask and enable-mask read 0x000000. The soft-reset register reads 0x001111. irq_o is 0, and port_a_rst_n and port_b_rst_n are 1.
- R2: A 0-to-1 change on req_i sets the status bit of that source. The source order is index 0 = port A output at bit 0, index 1 = port A input at bit 4, index 2 = port B output at bit 8, index 3 = port B input at bit 16. The bit is set at the first clock edge that samples the request high, and it stays set until cleared. A request held high does not set the bit again after a clear.
- R3: irq_o is 1 exactly when some source bit is set in all three of status, mask and enable-mask. Mask and enable-mask use the same bit positions as status.
- R4: A write to the status register (word address 0) clears each status bit written as 0 and leaves each bit written as 1 unchanged.
- R5: If a source edge and any status clear fall in the same cycle, the status bit ends up set.
- R6: The soft-reset register is at word address 3. Writing its bit 4 from 0 back to 1 clears all status bits. While bit 4 is 0, status is not cleared.
- R7: port_a_rst_n equals soft-reset bit 8 AND bit 0. port_b_rst_n equals soft-reset bit 12 AND bit 0. These bits are active low.
- R8: Writing soft-reset bit 0 from 0 back to 1 clears status, mask (word address 1) and enable-mask (word address 2).
- R9: Mask and enable-mask store only the four source bit positions; all other bits read 0. Addresses 4 to 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 4 | Source requests: A out, A in, B out, B in |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 24 | Write data |
| rdata | output | 24 | Read data for addr, combinational |
| irq_o | output | 1 | CPU interrupt |
| port_a_rst_n | output | 1 | Port A reset, active low |
| port_b_rst_n | output | 1 | Port B reset, active low |

## Verification
Every register write and every request edge takes effect at the next rising clock edge. After that edge, status, mask and the soft-reset outputs show the new value, and irq_o follows with no further register stage. The bench drives each stimulus on a falling edge and removes it on the next falling edge, so exactly one rising edge sees it. It then checks rdata and the outputs one nanosecond after that second falling edge, with rdata selected by address combinationally. The race case in R5 puts the request edge and the status clear in the same drive window, so both land on the same rising edge.

// File: rtl/aggr_pkg.sv
package aggr_pkg;
  localparam int NSRC   = 4;
  localparam int REG_W  = 24;
  localparam int ADDR_W = 3;

  // register word addresses
  localparam logic [ADDR_W-1:0] AD_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] AD_MASK  = 3'd1;
  localparam logic [ADDR_W-1:0] AD_ENMSK = 3'd2;
  localparam logic [ADDR_W-1:0] AD_SRST  = 3'd3;

  // source bit positions, shared by status, mask and enable-mask
  localparam int SRC_POS [NSRC] = '{0, 4, 8, 16};

  // soft-reset register bit positions, all active low
  localparam int SR_GLB = 0;
  localparam int SR_IRQ = 4;
  localparam int SR_PA  = 8;
  localparam int SR_PB  = 12;

  function automatic logic [NSRC-1:0] squeeze(input logic [REG_W-1:0] w);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++) r[i] = w[SRC_POS[i]];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] spread(input logic [NSRC-1:0] s);
    logic [REG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NSRC; i++) r[SRC_POS[i]] = s[i];
    return r;
  endfunction
endpackage

// File: rtl/aggr_edge.sv
module aggr_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] evt
);
  logic [N-1:0] req_q;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[i] <= 1'b0;
      else        req_q[i] <= req[i];
    end
    assign evt[i] = req[i] & ~req_q[i];
  end
endmodule

// File: rtl/aggr_softrst.sv
module aggr_softrst
  import aggr_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rd_val,
  output logic         irq_clr,
  output logic         glb_clr,
  output logic         pa_rst_n,
  output logic         pb_rst_n
);
  logic glb_q, irq_q, pa_q, pb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glb_q <= 1'b1;
      irq_q <= 1'b1;
      pa_q  <= 1'b1;
      pb_q  <= 1'b1;
    end else if (we) begin
      glb_q <= wdata[SR_GLB];
      irq_q <= wdata[SR_IRQ];
      pa_q  <= wdata[SR_PA];
      pb_q  <= wdata[SR_PB];
    end
  end

  // a clear fires on the write that brings an active-low bit back to 1
  assign irq_clr = we & wdata[SR_IRQ] & ~irq_q;
  assign glb_clr = we & wdata[SR_GLB] & ~glb_q;

  assign pa_rst_n = pa_q & glb_q;
  assign pb_rst_n = pb_q & glb_q;

  always_comb begin
    rd_val = '0;
    rd_val[SR_GLB] = glb_q;
    rd_val[SR_IRQ] = irq_q;
    rd_val[SR_PA]  = pa_q;
    rd_val[SR_PB]  = pb_q;
  end

  // R7
  port_rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[SR_GLB]) |=> (!pa_rst_n && !pb_rst_n));
endmodule

// File: rtl/aggr_status.sv
module aggr_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         we,
  input  logic [N-1:0] wbits,
  input  logic         clr_all,
  output logic [N-1:0] stat
);
  logic [N-1:0] stat_nx;

  always_comb begin
    stat_nx = stat;
    if (we)      stat_nx = stat_nx & wbits;
    if (clr_all) stat_nx = '0;
    stat_nx = stat_nx | evt;   // a source edge beats any clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= stat_nx;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R5
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> stat[i]);
  end

  // R4
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr_all && evt == '0) |=> (stat == $past(stat & wbits)));

  // R2
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !clr_all && evt == '0) |=> $stable(stat));

  // R6
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && evt == '0) |=> (stat == '0));
endmodule

// File: rtl/audio_irq_aggr.sv
module audio_irq_aggr
  import aggr_pkg::*;
#(
  parameter int SRC_N = NSRC,
  parameter int DW    = REG_W,
  parameter int AW    = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] req_i,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             irq_o,
  output logic             port_a_rst_n,
  output logic             port_b_rst_n
);
  logic [SRC_N-1:0] evt, stat, mask_q, en_q, wsrc;
  logic [DW-1:0]    srst_rd;
  logic             irq_clr, glb_clr;
  logic             unused_wbits;

  assign unused_wbits = ^wdata;
  assign wsrc = squeeze(wdata);

  aggr_edge #(.N(SRC_N)) u_edge (
    .clk(clk), .rst_n(rst_n), .req(req_i), .evt(evt)
  );

  aggr_softrst #(.W(DW)) u_srst (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en && addr == AD_SRST), .wdata(wdata),
    .rd_val(srst_rd), .irq_clr(irq_clr), .glb_clr(glb_clr),
    .pa_rst_n(port_a_rst_n), .pb_rst_n(port_b_rst_n)
  );

  aggr_status #(.N(SRC_N)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .we(wr_en && addr == AD_STAT), .wbits(wsrc),
    .clr_all(irq_clr | glb_clr), .stat(stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= '0;
    end else if (glb_clr) begin
      mask_q <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      if (addr == AD_MASK)  mask_q <= wsrc;
      if (addr == AD_ENMSK) en_q   <= wsrc;
    end
  end

  always_comb begin
    unique case (addr)
      AD_STAT:  rdata = spread(stat);
      AD_MASK:  rdata = spread(mask_q);
      AD_ENMSK: rdata = spread(en_q);
      AD_SRST:  rdata = srst_rd;
      default:  rdata = '0;
    endcase
  end

  assign irq_o = |(stat & mask_q & en_q);

  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_q & en_q) == '0) |-> !irq_o);

  // R8
  glb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glb_clr |=> (mask_q == '0 && en_q == '0));
endmodule

// File: tb/audio_irq_aggr_test.sv
module audio_irq_aggr_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  req_i = '0;
  logic        wr_en = 0;
  logic [2:0]  addr = '0;
  logic [23:0] wdata = '0;
  logic [23:0] rdata;
  logic        irq_o, port_a_rst_n, port_b_rst_n;
  int errors = 0;
  int checks = 0;

  localparam logic [23:0] ALL = 24'h010111;

  audio_irq_aggr uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o),
    .port_a_rst_n(port_a_rst_n), .port_b_rst_n(port_b_rst_n)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse(input logic [3:0] m);
    @(negedge clk);
    req_i = req_i | m;
    @(negedge clk);
    req_i = req_i & ~m;
    #1;
  endtask

  task automatic t_reset;
    logic [23:0] v;
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 mask", v, 0);
    rd(2, v); chk("R1 enmask", v, 0);
    rd(3, v); chk("R1 softrst", v, 24'h001111);
    chk("R1 irq", irq_o, 0);
    chk("R1 port rst", {port_a_rst_n, port_b_rst_n}, 2'b11);
  endtask

  task automatic t_latch;
    logic [23:0] v;
    pulse(4'b0001); rd(0, v); chk("R2 A out", v, 24'h000001);
    pulse(4'b1000); rd(0, v); chk("R2 B in", v, 24'h010001);
    @(negedge clk); req_i[1] = 1;
    @(negedge clk); #1; rd(0, v); chk("R2 A in held", v, 24'h010011);
    wr(0, 24'h0); rd(0, v); chk("R2 no relatch while held", v, 0);
    @(negedge clk); #1; rd(0, v); chk("R2 still clear", v, 0);
    req_i[1] = 0;
    chk("R3 masks zero", irq_o, 0);
  endtask

  task automatic t_mask;
    pulse(4'b0100);
    wr(1, 24'h000100); chk("R3 mask only", irq_o, 0);
    wr(1, 24'h0); wr(2, 24'h000100); chk("R3 enable only", irq_o, 0);
    wr(1, 24'h000100); chk("R3 both", irq_o, 1);
    wr(1, 24'h000001); chk("R3 different bit", irq_o, 0);
    wr(1, 24'h0); wr(2, 24'h0); wr(0, 24'h0);
  endtask

  task automatic t_wclr;
    logic [23:0] v;
    pulse(4'b1111); rd(0, v); chk("R2 all four", v, ALL);
    wr(0, 24'hFFFFEF); rd(0, v); chk("R4 clear bit 4", v, 24'h010101);
    wr(0, 24'h0); rd(0, v); chk("R4 write zero", v, 0);
  endtask

  task automatic t_race;
    logic [23:0] v;
    @(negedge clk);
    req_i = 4'b0100; wr_en = 1; addr = 0; wdata = 24'h0;
    @(negedge clk);
    req_i = 0; wr_en = 0; #1;
    rd(0, v); chk("R5 event beats write clear", v, 24'h000100);
    wr(3, 24'h001101);
    @(negedge clk);
    req_i = 4'b0001; wr_en = 1; addr = 3; wdata = 24'h001111;
    @(negedge clk);
    req_i = 0; wr_en = 0; #1;
    rd(0, v); chk("R5 event beats irq reset", v, 24'h000001);
    wr(0, 24'h0);
  endtask

  task automatic t_irqrst;
    logic [23:0] v;
    pulse(4'b1010);
    wr(3, 24'h001101); rd(0, v); chk("R6 held while low", v, 24'h010010);
    rd(3, v); chk("R6 readback", v, 24'h001101);
    wr(3, 24'h001111); rd(0, v); chk("R6 clear on release", v, 0);
  endtask

  task automatic t_port;
    wr(3, 24'h001011); chk("R7 port A", {port_a_rst_n, port_b_rst_n}, 2'b01);
    wr(3, 24'h000111); chk("R7 port B", {port_a_rst_n, port_b_rst_n}, 2'b10);
    wr(3, 24'h001110); chk("R7 global", {port_a_rst_n, port_b_rst_n}, 2'b00);
    wr(3, 24'h001111); chk("R7 released", {port_a_rst_n, port_b_rst_n}, 2'b11);
  endtask

  task automatic t_glob;
    logic [23:0] v;
    pulse(4'b0010);
    wr(1, 24'h000010); wr(2, 24'h000010);
    chk("R8 irq before", irq_o, 1);
    wr(3, 24'h001110); wr(3, 24'h001111);
    rd(0, v); chk("R8 status", v, 0);
    rd(1, v); chk("R8 mask", v, 0);
    rd(2, v); chk("R8 enmask", v, 0);
    chk("R8 irq", irq_o, 0);
  endtask

  task automatic t_map;
    logic [23:0] v;
    wr(1, 24'hFFFFFF); rd(1, v); chk("R9 mask bits", v, ALL);
    wr(2, 24'hFFFFFF); rd(2, v); chk("R9 enmask bits", v, ALL);
    wr(5, 24'h000000); rd(5, v); chk("R9 unmapped read", v, 0);
    rd(1, v); chk("R9 unmapped write ignored", v, ALL);
    wr(1, 24'h0); wr(2, 24'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset;
    t_latch;
    t_mask;
    t_wclr;
    t_race;
    t_irqrst;
    t_port;
    t_glob;
    t_map;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule